// File: doc/BRIEF.md
# Sparse Configurable Routing Switch Box

This block is the routing matrix of one tile in a small programmable fabric. It holds a bank of local switch wires. Each switch wire is the output of a configurable multiplexer whose candidates are a constant 0, a constant 1, one wire arriving from each of the eight neighbouring tiles, and a few of the tile's logic outputs. Each logic input of the tile is in turn fed by a configurable multiplexer that can reach only a sparse, strided subset of the switch wires. Neighbour taps are rotated by direction, so wire j takes a different wire index from each neighbour. Full crossbar connectivity is not provided.

Every multiplexer select is held in a configuration store. The store is loaded through a serial shift chain while a configuration-enable input is high. The new settings are transferred to the active copy only when the enable drops. As a result, the routing already in place keeps working undisturbed during a reload. The chain's far end is brought out so that tiles can be daisy-chained. The neighbour-facing outputs repeat the local switch wires in all eight directions.

Top module: `swb_tile`

## Requirements
- R1: With default parameters the tile has 56 switch wires, 32 logic inputs and 16 logic outputs. The neighbour buses carry direction k (0..7, in the order N, NE, E, SE, S, SW, W, NW) wire i at bit k*56+i.
- R2: Switch wire select codes: 0 means undriven, and the wire reads 0. Code 1 drives constant 0. Code 2 drives constant 1.
- R3: Switch wire j with select code 3+k (k = 0..7) follows the wire from direction k whose index is (j+k) mod 56.
- R4: Switch wire j with select code 11+m follows logic output m*6 + (j mod 6) when that index is below 16. Otherwise the wire reads 0. Codes 11..15 are in this group.
- R5: Logic input i with select code c >= 1 follows switch wire (c-1)*6 + (i mod 6) when that index is below 56. Otherwise, and for code 0, the input reads 0.
- R6: The configuration chain is 352 bits long. Switch wire j's 4-bit select sits at bits 4j+3..4j. Logic input i's select sits at bits 224+4i+3..224+4i. Bits are shifted in LSB first, one per clock while the enable is high. The chain does not move while the enable is low.
- R7: The active configuration does not change while the enable is high. It takes the shifted contents on the first clock edge at which the enable is sampled low after being high. The outputs reflect the new setting from then on.
- R8: The chain output is bit 0 of the chain. During a reload it therefore emits the previously stored configuration in bit order.
- R9: Neighbour output wire i in every direction equals switch wire i.
- R10: After reset the chain and the active configuration are all zero, and every routed output reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Configuration shift enable; dropping it commits the chain |
| cfg_in | input | 1 | Serial configuration data in |
| cfg_out | output | 1 | Serial configuration data out (chain bit 0) |
| lout_i | input | 16 | Logic outputs of the tile |
| nb_in | input | 448 | Wires arriving from the eight neighbours |
| lin_o | output | 32 | Logic inputs of the tile |
| nb_out | output | 448 | Wires leaving toward the eight neighbours |

## Verification
Shifting a new configuration and routing live data under the old one happen in the same cycles. The bench provokes this by changing the logic outputs and neighbour wires in the middle of a reload. It expects the outputs to follow the configuration that is still committed. This judgement is also made in the cycle where the enable has just dropped but the commit edge has not yet arrived. In the cycle after that edge, the bench judges the outputs against the new configuration. On the same reload, the chain output is compared bit by bit with the previously loaded vector.

// File: rtl/swb_pkg.sv
package swb_pkg;

    function automatic int cdiv(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    function automatic int clog2i(input int v);
        int r;
        r = 0;
        while ((1 << r) < v) r++;
        return (r < 1) ? 1 : r;
    endfunction

    // count of indices x < lim with x mod stride == res
    function automatic int stride_count(input int lim, input int stride, input int res);
        return (res < lim) ? cdiv(lim - res, stride) : 0;
    endfunction

endpackage

// File: rtl/swb_cfg_chain.sv
module swb_cfg_chain #(
    parameter int TOT = 352
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_en,
    input  logic           cfg_in,
    output logic           cfg_out,
    output logic [TOT-1:0] sh_o,
    output logic [TOT-1:0] act_o
);

    typedef struct packed {
        logic [TOT-1:0] shift;
        logic [TOT-1:0] act;
        logic           en;
    } chain_t;

    chain_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_en) begin
            st_d.shift = {cfg_in, st_q.shift[TOT-1:1]};
        end
        if (st_q.en && !cfg_en) begin
            st_d.act = st_q.shift;
        end
        st_d.en = cfg_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_out = st_q.shift[0];
    assign sh_o    = st_q.shift;
    assign act_o   = st_q.act;

endmodule

// File: rtl/swb_wire_mux.sv
module swb_wire_mux
    import swb_pkg::*;
#(
    parameter int J    = 0,
    parameter int NDIR = 8,
    parameter int NOUT = 16,
    parameter int SQ   = 6,
    parameter int SELW = 4
) (
    input  logic [SELW-1:0] sel,
    input  logic [NDIR-1:0] nb_tap,
    input  logic [NOUT-1:0] lout,
    output logic            y
);

    localparam int RES   = J % SQ;
    localparam int NLO   = stride_count(NOUT, SQ, RES);
    localparam int BASE  = 3 + NDIR;
    localparam int NCODE = 1 << SELW;

    logic [NCODE-1:0] cand;

    always_comb begin
        cand    = '0;
        cand[2] = 1'b1;
        for (int k = 0; k < NDIR; k++) begin
            if (3 + k < NCODE) cand[3 + k] = nb_tap[k];
        end
        for (int m = 0; m < NLO; m++) begin
            if (BASE + m < NCODE) cand[BASE + m] = lout[m * SQ + RES];
        end
    end

    assign y = cand[sel];

endmodule

// File: rtl/swb_in_mux.sv
module swb_in_mux
    import swb_pkg::*;
#(
    parameter int I    = 0,
    parameter int NW   = 56,
    parameter int SI   = 6,
    parameter int SELW = 4
) (
    input  logic [SELW-1:0] sel,
    input  logic [NW-1:0]   sw,
    output logic            y
);

    localparam int RES   = I % SI;
    localparam int NSW   = stride_count(NW, SI, RES);
    localparam int NCODE = 1 << SELW;

    logic [NCODE-1:0] cand;

    always_comb begin
        cand = '0;
        for (int m = 0; m < NSW; m++) begin
            if (1 + m < NCODE) cand[1 + m] = sw[m * SI + RES];
        end
    end

    assign y = cand[sel];

endmodule

// File: rtl/swb_tile.sv
module swb_tile
    import swb_pkg::*;
#(
    parameter int CELLS = 8,
    parameter int LUT_K = 4,
    parameter int EXTRA = 16,
    parameter int NDIR  = 8,
    parameter int SI    = 6,
    parameter int SQ    = 6,
    localparam int NW   = CELLS * (LUT_K + 1) + EXTRA,
    localparam int NIN  = CELLS * LUT_K,
    localparam int NOUT = CELLS * 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_en,
    input  logic               cfg_in,
    output logic               cfg_out,
    input  logic [NOUT-1:0]    lout_i,
    input  logic [NDIR*NW-1:0] nb_in,
    output logic [NIN-1:0]     lin_o,
    output logic [NDIR*NW-1:0] nb_out
);

    localparam int SW_SELW = clog2i(3 + NDIR + cdiv(NOUT, SQ));
    localparam int IN_SELW = clog2i(1 + cdiv(NW, SI));
    localparam int SW_BITS = NW * SW_SELW;
    localparam int TOT     = SW_BITS + NIN * IN_SELW;

    logic [TOT-1:0] sh_cfg;
    logic [TOT-1:0] act_cfg;
    logic [NW-1:0]  sw_w;

    swb_cfg_chain #(.TOT(TOT)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_en  (cfg_en),
        .cfg_in  (cfg_in),
        .cfg_out (cfg_out),
        .sh_o    (sh_cfg),
        .act_o   (act_cfg)
    );

    for (genvar j = 0; j < NW; j++) begin : g_wire
        logic [NDIR-1:0] tap;
        for (genvar k = 0; k < NDIR; k++) begin : g_tap
            assign tap[k] = nb_in[k * NW + ((j + k) % NW)];
        end
        swb_wire_mux #(
            .J(j), .NDIR(NDIR), .NOUT(NOUT), .SQ(SQ), .SELW(SW_SELW)
        ) u_mux (
            .sel    (act_cfg[j * SW_SELW +: SW_SELW]),
            .nb_tap (tap),
            .lout   (lout_i),
            .y      (sw_w[j])
        );
    end

    for (genvar i = 0; i < NIN; i++) begin : g_in
        swb_in_mux #(
            .I(i), .NW(NW), .SI(SI), .SELW(IN_SELW)
        ) u_mux (
            .sel (act_cfg[SW_BITS + i * IN_SELW +: IN_SELW]),
            .sw  (sw_w),
            .y   (lin_o[i])
        );
    end

    for (genvar k = 0; k < NDIR; k++) begin : g_nbo
        assign nb_out[k * NW +: NW] = sw_w;
    end

endmodule

// File: rtl/swb_chk.sv
module swb_chk #(
    parameter int NW      = 56,
    parameter int NIN     = 32,
    parameter int SI      = 6,
    parameter int SW_SELW = 4,
    parameter int IN_SELW = 4,
    parameter int TOT     = 352
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cfg_en,
    input logic           cfg_out,
    input logic [TOT-1:0] sh_cfg,
    input logic [TOT-1:0] act_cfg,
    input logic [NW-1:0]  sw_w,
    input logic [NIN-1:0] lin_o
);

    localparam int SWIW    = (NW > 1) ? $clog2(NW) : 1;
    localparam int SW_BITS = NW * SW_SELW;

    logic [NIN-1:0] route_ok;

    always_comb begin
        for (int i = 0; i < NIN; i++) begin
            int c;
            int idx;
            c   = int'(act_cfg[SW_BITS + i * IN_SELW +: IN_SELW]);
            idx = (c - 1) * SI + (i % SI);
            if (c == 0 || idx >= NW) route_ok[i] = !lin_o[i];
            else route_ok[i] = (lin_o[i] == sw_w[SWIW'(idx)]);
        end
    end

    AST_HOLD_WHILE_LOADING: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> $stable(act_cfg)); // R7
    AST_COMMIT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_en) |=> (act_cfg == $past(sh_cfg))); // R7
    AST_CHAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> (cfg_out == $past(sh_cfg[1]))); // R8
    AST_CHAIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> $stable(sh_cfg)); // R6
    AST_IN_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        &route_ok); // R5

    for (genvar j = 0; j < NW; j++) begin : g_w
        AST_LOW_CODES: assert property (@(posedge clk) disable iff (!rst_n)
            (act_cfg[j * SW_SELW +: SW_SELW] < 2) |-> !sw_w[j]); // R2
        AST_CONST_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            (act_cfg[j * SW_SELW +: SW_SELW] == 2) |-> sw_w[j]); // R2
    end

endmodule

bind swb_tile swb_chk #(
    .NW(NW), .NIN(NIN), .SI(SI), .SW_SELW(SW_SELW), .IN_SELW(IN_SELW), .TOT(TOT)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_en  (cfg_en),
    .cfg_out (cfg_out),
    .sh_cfg  (sh_cfg),
    .act_cfg (act_cfg),
    .sw_w    (sw_w),
    .lin_o   (lin_o)
);

// File: tb/sim_swb_tile.sv
module sim_swb_tile;

    localparam int CLK_PERIOD = 10;
    localparam int NW   = 56;
    localparam int NIN  = 32;
    localparam int NOUT = 16;
    localparam int NDIR = 8;
    localparam int SELW = 4;
    localparam int TOT  = NW * SELW + NIN * SELW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_en = 1'b0;
    logic cfg_in = 1'b0;
    logic cfg_out;
    logic [NOUT-1:0] lout_i = '0;
    logic [NDIR*NW-1:0] nb_in = '0;
    logic [NIN-1:0] lin_o;
    logic [NDIR*NW-1:0] nb_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    int cur_sw [NW];
    int cur_in [NIN];
    int nx_sw  [NW];
    int nx_in  [NIN];

    always #(CLK_PERIOD / 2) clk = ~clk;

    swb_tile u0 (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_in(cfg_in), .cfg_out(cfg_out),
        .lout_i(lout_i), .nb_in(nb_in), .lin_o(lin_o), .nb_out(nb_out)
    );

    // R2, R3, R4: expected switch wire values from the committed codes
    function automatic logic [NW-1:0] f_sw();
        logic [NW-1:0] v;
        v = '0;
        for (int j = 0; j < NW; j++) begin
            int c;
            c = cur_sw[j];
            if (c == 2) v[j] = 1'b1;
            else if (c >= 3 && c < 3 + NDIR) v[j] = nb_in[(c - 3) * NW + (j + c - 3) % NW];
            else if (c >= 3 + NDIR) begin
                int i;
                i = (c - 3 - NDIR) * 6 + j % 6;
                if (i < NOUT) v[j] = lout_i[i];
            end
        end
        return v;
    endfunction

    // R5: expected logic inputs
    function automatic logic [NIN-1:0] f_lin(input logic [NW-1:0] sw);
        logic [NIN-1:0] v;
        v = '0;
        for (int i = 0; i < NIN; i++) begin
            int c;
            c = cur_in[i];
            if (c != 0 && (c - 1) * 6 + i % 6 < NW) v[i] = sw[(c - 1) * 6 + i % 6];
        end
        return v;
    endfunction

    task automatic check_out(input string tag);
        logic [NW-1:0] esw;
        logic [NIN-1:0] elin;
        logic [NDIR*NW-1:0] enb;
        esw  = f_sw();
        elin = f_lin(esw);
        enb  = {NDIR{esw}};
        n_chk++;
        if (nb_out !== enb) begin
            n_bad++;
            $display("FAIL %s R9: nb_out got %h exp %h", tag, nb_out, enb);
        end
        n_chk++;
        if (lin_o !== elin) begin
            n_bad++;
            $display("FAIL %s R5: lin_o got %h exp %h", tag, lin_o, elin);
        end
    endtask

    task automatic rand_inputs();
        for (int b = 0; b < NDIR * NW; b++) nb_in[b] = 1'($urandom);
        for (int b = 0; b < NOUT; b++) lout_i[b] = 1'($urandom);
    endtask

    function automatic logic [TOT-1:0] pack(input bit use_next);
        logic [TOT-1:0] v;
        for (int j = 0; j < NW; j++) v[4 * j +: 4] = 4'(use_next ? nx_sw[j] : cur_sw[j]);
        for (int i = 0; i < NIN; i++) v[NW * 4 + 4 * i +: 4] = 4'(use_next ? nx_in[i] : cur_in[i]);
        return v;
    endfunction

    // R6, R7, R8: serial load with hold and chain-out checks
    task automatic do_load();
        logic [TOT-1:0] v;
        logic [TOT-1:0] old;
        int bad;
        v = pack(1);
        old = pack(0);
        bad = 0;
        for (int t = 0; t < TOT; t++) begin
            @(negedge clk);
            if (cfg_out !== old[t]) bad++;
            cfg_en = 1'b1;
            cfg_in = v[t];
            if (t == 100 || t == 300) begin
                rand_inputs();
                #1 check_out("R7 hold mid-load");
            end
        end
        n_chk++;
        if (bad != 0) begin
            n_bad++;
            $display("FAIL R8: cfg_out mismatched bits got %0d exp %0d", bad, 0);
        end
        @(negedge clk);
        cfg_en = 1'b0;
        cfg_in = 1'b0;
        rand_inputs();
        #1 check_out("R7 before commit");
        @(negedge clk);
        for (int j = 0; j < NW; j++) cur_sw[j] = nx_sw[j];
        for (int i = 0; i < NIN; i++) cur_in[i] = nx_in[i];
        check_out("R6/R7 after commit");
    endtask

    initial begin
        for (int j = 0; j < NW; j++) cur_sw[j] = 0;
        for (int i = 0; i < NIN; i++) cur_in[i] = 0;
        rand_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R10 reset");
        n_chk++;
        if (cfg_out !== 1'b0) begin
            n_bad++;
            $display("FAIL R10: cfg_out got %b exp %b", cfg_out, 1'b0);
        end

        // every code on some wire and input
        for (int j = 0; j < NW; j++) nx_sw[j] = j % 16;
        for (int i = 0; i < NIN; i++) nx_in[i] = i % 16;
        do_load();
        for (int p = 0; p < 6; p++) begin
            @(negedge clk); rand_inputs(); #1 check_out("R2/R4/R5 mixed codes");
        end

        // R1, R3: every neighbour direction in turn
        for (int k = 0; k < NDIR; k++) begin
            for (int j = 0; j < NW; j++) nx_sw[j] = 3 + k;
            for (int i = 0; i < NIN; i++) nx_in[i] = (i + k) % 16;
            do_load();
            for (int p = 0; p < 3; p++) begin
                @(negedge clk); rand_inputs(); #1 check_out("R1/R3 neighbour");
            end
        end

        // R4: logic output codes, including the out-of-range ones
        for (int m = 0; m < 5; m++) begin
            for (int j = 0; j < NW; j++) nx_sw[j] = 11 + m;
            for (int i = 0; i < NIN; i++) nx_in[i] = (2 * i + m) % 16;
            do_load();
            for (int p = 0; p < 3; p++) begin
                @(negedge clk); rand_inputs(); #1 check_out("R4 logic outputs");
            end
        end

        // R2: constants and undriven
        for (int j = 0; j < NW; j++) nx_sw[j] = 2;
        for (int i = 0; i < NIN; i++) nx_in[i] = i % 16;
        do_load();
        @(negedge clk); rand_inputs(); #1 check_out("R2 const one");
        for (int j = 0; j < NW; j++) nx_sw[j] = j % 2;
        do_load();
        @(negedge clk); rand_inputs(); #1 check_out("R2 const zero/undriven");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: cycles got %0d exp %0d", 200000, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule